// File: doc/BRIEF.md
# AXI4-Lite Register Bridge

This block is an AXI4-Lite slave that sits on a CPU-side clock and turns each bus transaction into one access on a simple single-port register interface that runs on an independent user clock. A write becomes a single-cycle write strobe that carries a word address, 32 data bits and four byte enables, the same as a write to a single-port RAM. A read becomes a single-cycle read-request strobe with a word address. The bridge then waits, for however many user cycles the register file needs, until the register file raises read-valid with the data. That data goes back on the AXI4-Lite read channel.

The bus side accepts one transaction at a time and holds its address, data and byte enables in registers until the user side confirms that the access has finished. A request toggles a flag that crosses into the user domain through a multi-flop synchroniser, and the completion toggles a flag that crosses back the same way. Reads and writes share one address bus on the register side, so at most one access is ever in flight. When a read and a write reach the bus in the same cycle, the read goes first.

Top module: `axil_reg_bridge`

## Requirements
- R1: Each accepted AXI write produces exactly one `reg_wr_en` pulse, one user cycle long. The pulse carries `reg_addr` = byte address bits [ADDR_W-1:2] (bits [1:0] are dropped), together with the written data.
- R2: The byte enables reach `reg_be` unchanged. Bit i qualifies `reg_wdata` bits [8i+7:8i], so a register file that merges by enable keeps the bytes whose bit is 0.
- R3: Each accepted AXI read produces exactly one `reg_rd_req` pulse, one user cycle long. `rdata` returns the `reg_rd_data` value seen in the cycle `reg_rd_valid` is high, whatever the read latency.
- R4: `reg_addr` stays stable from the `reg_rd_req` pulse until `reg_rd_valid` is returned.
- R5: `reg_wr_en` and `reg_rd_req` are never high together. No new access starts before the previous one has completed, and `bvalid` and `rvalid` are never high together.
- R6: When `arvalid`, `awvalid` and `wvalid` are high in the same idle cycle, the read is accepted first, with `awready`/`wready` low. The write is performed only after the read's register access, so the read returns the old value.
- R7: `bresp` and `rresp` are always 2'b00 (OKAY).
- R8: `bvalid` and `rvalid` stay high, with `rdata` unchanged, until the matching ready is seen.
- R9: After reset, `bvalid`, `rvalid`, `reg_wr_en` and `reg_rd_req` are 0 and `arready` is 1.
- R10: The register port sees no access without a bus transaction. The number of write and read strobes equals the number of accepted AXI writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Bus-domain reset, active low |
| awaddr | input | ADDR_W | Write byte address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| araddr | input | ADDR_W | Read byte address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |
| uclk | input | 1 | User (register) clock |
| urst_n | input | 1 | User-domain reset, active low |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_rd_req | output | 1 | Single-cycle read request |
| reg_addr | output | ADDR_W-2 | Word address shared by reads and writes |
| reg_wdata | output | DATA_W | Write data |
| reg_be | output | DATA_W/8 | Write byte enables |
| reg_rd_valid | input | 1 | Read data valid from register file |
| reg_rd_data | input | DATA_W | Read data from register file |

## Verification
The embedded properties check on every cycle that the strobes are single pulses and never overlap, and that the register address stays put while a read is pending. They also check that responses hold until taken, that a read wins a same-cycle contest, and that the bus-side payload stays frozen while the handshake is in flight. The bench scenarios are needed for the end-to-end facts that span both clock domains. These are the word-address mapping, the byte-enable merge, the returned read data under random register latency, the one-strobe-per-transaction count, and the ordering of a colliding read and write.

// File: rtl/axil_bridge_pkg.sv
package axil_bridge_pkg;

   // bus-domain sequencer
   typedef enum logic [1:0] {
      BS_IDLE = 2'd0,
      BS_WAIT = 2'd1,
      BS_RESP = 2'd2
   } bus_state_t;

   // user-domain sequencer
   typedef enum logic {
      US_IDLE = 1'b0,
      US_READ = 1'b1
   } usr_state_t;

   localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/cdc_bit_sync.sv
module cdc_bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cdc_bit_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/axil_bus_side.sv
module axil_bus_side
   import axil_bridge_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 32,
   localparam int BE_W  = DATA_W / 8,
   localparam int RA_W  = ADDR_W - 2
) (
   input  logic              aclk,
   input  logic              aresetn,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BE_W-1:0]   wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   // crossing handshake
   output logic              req_tgl,
   output logic              hold_is_rd,
   output logic [RA_W-1:0]   hold_addr,
   output logic [DATA_W-1:0] hold_data,
   output logic [BE_W-1:0]   hold_be,
   input  logic              ack_tgl_s,
   input  logic [DATA_W-1:0] ret_data
);

   bus_state_t st;
   logic       ack_seen;
   logic       take_rd, take_wr, ack_edge;

   assign arready  = (st == BS_IDLE);
   assign take_rd  = arready && arvalid;
   // read wins when both arrive together
   assign take_wr  = (st == BS_IDLE) && awvalid && wvalid && !arvalid;
   assign awready  = take_wr;
   assign wready   = take_wr;
   assign ack_edge = (ack_tgl_s != ack_seen);
   assign bresp    = RESP_OKAY;
   assign rresp    = RESP_OKAY;

   always_ff @(posedge aclk or negedge aresetn) begin
      if (!aresetn) begin
         st         <= BS_IDLE;
         req_tgl    <= 1'b0;
         ack_seen   <= 1'b0;
         hold_is_rd <= 1'b0;
         hold_addr  <= '0;
         hold_data  <= '0;
         hold_be    <= '0;
         bvalid     <= 1'b0;
         rvalid     <= 1'b0;
         rdata      <= '0;
      end else begin
         case (st)
            BS_IDLE: begin
               if (take_rd) begin
                  hold_is_rd <= 1'b1;
                  hold_addr  <= araddr[ADDR_W-1:2];
                  req_tgl    <= ~req_tgl;
                  st         <= BS_WAIT;
               end else if (take_wr) begin
                  hold_is_rd <= 1'b0;
                  hold_addr  <= awaddr[ADDR_W-1:2];
                  hold_data  <= wdata;
                  hold_be    <= wstrb;
                  req_tgl    <= ~req_tgl;
                  st         <= BS_WAIT;
               end
            end
            BS_WAIT: begin
               if (ack_edge) begin
                  ack_seen <= ack_tgl_s;
                  if (hold_is_rd) begin
                     rvalid <= 1'b1;
                     rdata  <= ret_data;
                  end else begin
                     bvalid <= 1'b1;
                  end
                  st <= BS_RESP;
               end
            end
            BS_RESP: begin
               if (rvalid && rready) begin
                  rvalid <= 1'b0;
                  st     <= BS_IDLE;
               end else if (bvalid && bready) begin
                  bvalid <= 1'b0;
                  st     <= BS_IDLE;
               end
            end
            default: st <= BS_IDLE;
         endcase
      end
   end

   // R6: a read accepted in a cycle shuts out the write
   p_read_first_r6: assert property (@(posedge aclk) disable iff (!aresetn)
      (arvalid && arready) |-> !(awvalid && awready));
   // R8: responses hold until taken
   p_bhold_r8: assert property (@(posedge aclk) disable iff (!aresetn)
      (bvalid && !bready) |=> bvalid);
   p_rhold_r8: assert property (@(posedge aclk) disable iff (!aresetn)
      (rvalid && !rready) |=> (rvalid && $stable(rdata)));
   // R5: one response at a time
   p_one_resp_r5: assert property (@(posedge aclk) disable iff (!aresetn)
      !(bvalid && rvalid));
   // R4: payload frozen while the crossing is in flight
   p_hold_addr_r4: assert property (@(posedge aclk) disable iff (!aresetn)
      (st == BS_WAIT) |=> $stable(hold_addr));

endmodule

// File: rtl/reg_user_side.sv
module reg_user_side
   import axil_bridge_pkg::*;
#(
   parameter int RA_W   = 16,
   parameter int DATA_W = 32,
   localparam int BE_W  = DATA_W / 8
) (
   input  logic              uclk,
   input  logic              urst_n,
   input  logic              req_tgl_s,
   input  logic              hold_is_rd,
   input  logic [RA_W-1:0]   hold_addr,
   input  logic [DATA_W-1:0] hold_data,
   input  logic [BE_W-1:0]   hold_be,
   output logic              ack_tgl,
   output logic [DATA_W-1:0] ret_data,
   output logic              reg_wr_en,
   output logic              reg_rd_req,
   output logic [RA_W-1:0]   reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic [BE_W-1:0]   reg_be,
   input  logic              reg_rd_valid,
   input  logic [DATA_W-1:0] reg_rd_data
);

   usr_state_t us;
   logic       req_seen;
   logic       req_edge;

   assign req_edge = (req_tgl_s != req_seen);

   always_ff @(posedge uclk or negedge urst_n) begin
      if (!urst_n) begin
         us         <= US_IDLE;
         req_seen   <= 1'b0;
         ack_tgl    <= 1'b0;
         ret_data   <= '0;
         reg_wr_en  <= 1'b0;
         reg_rd_req <= 1'b0;
         reg_addr   <= '0;
         reg_wdata  <= '0;
         reg_be     <= '0;
      end else begin
         reg_wr_en  <= 1'b0;
         reg_rd_req <= 1'b0;
         case (us)
            US_IDLE: begin
               if (req_edge) begin
                  req_seen <= req_tgl_s;
                  reg_addr <= hold_addr;
                  if (hold_is_rd) begin
                     reg_rd_req <= 1'b1;
                     us         <= US_READ;
                  end else begin
                     reg_wdata <= hold_data;
                     reg_be    <= hold_be;
                     reg_wr_en <= 1'b1;
                     ack_tgl   <= ~ack_tgl;
                  end
               end
            end
            US_READ: begin
               if (reg_rd_valid) begin
                  ret_data <= reg_rd_data;
                  ack_tgl  <= ~ack_tgl;
                  us       <= US_IDLE;
               end
            end
            default: us <= US_IDLE;
         endcase
      end
   end

   // R5: shared address bus, never both strobes
   p_no_overlap_r5: assert property (@(posedge uclk) disable iff (!urst_n)
      !(reg_wr_en && reg_rd_req));
   // R1: write strobe is one cycle long
   p_wr_pulse_r1: assert property (@(posedge uclk) disable iff (!urst_n)
      reg_wr_en |=> !reg_wr_en);
   // R3: read request is one cycle long
   p_rd_pulse_r3: assert property (@(posedge uclk) disable iff (!urst_n)
      reg_rd_req |=> !reg_rd_req);
   // R4: address stable while the read is outstanding
   p_addr_stable_r4: assert property (@(posedge uclk) disable iff (!urst_n)
      (us == US_READ && !reg_rd_valid) |=> $stable(reg_addr));

endmodule

// File: rtl/axil_reg_bridge.sv
module axil_reg_bridge #(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int BE_W       = DATA_W / 8,
   localparam int RA_W       = ADDR_W - 2
) (
   input  logic              aclk,
   input  logic              aresetn,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BE_W-1:0]   wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   input  logic              uclk,
   input  logic              urst_n,
   output logic              reg_wr_en,
   output logic              reg_rd_req,
   output logic [RA_W-1:0]   reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic [BE_W-1:0]   reg_be,
   input  logic              reg_rd_valid,
   input  logic [DATA_W-1:0] reg_rd_data
);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("axil_reg_bridge: DATA_W must be 32");
      end
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr
         $error("axil_reg_bridge: ADDR_W must be 3..32");
      end
   endgenerate

   logic              req_tgl, req_tgl_s;
   logic              ack_tgl, ack_tgl_s;
   logic              hold_is_rd;
   logic [RA_W-1:0]   hold_addr;
   logic [DATA_W-1:0] hold_data;
   logic [BE_W-1:0]   hold_be;
   logic [DATA_W-1:0] ret_data;

   axil_bus_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .aclk(aclk), .aresetn(aresetn),
      .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
      .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
      .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .araddr(araddr), .arvalid(arvalid), .arready(arready),
      .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
      .req_tgl(req_tgl), .hold_is_rd(hold_is_rd), .hold_addr(hold_addr),
      .hold_data(hold_data), .hold_be(hold_be),
      .ack_tgl_s(ack_tgl_s), .ret_data(ret_data)
   );

   cdc_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(uclk), .rst_n(urst_n), .d(req_tgl), .q(req_tgl_s)
   );

   cdc_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(aclk), .rst_n(aresetn), .d(ack_tgl), .q(ack_tgl_s)
   );

   reg_user_side #(.RA_W(RA_W), .DATA_W(DATA_W)) u_usr (
      .uclk(uclk), .urst_n(urst_n),
      .req_tgl_s(req_tgl_s), .hold_is_rd(hold_is_rd), .hold_addr(hold_addr),
      .hold_data(hold_data), .hold_be(hold_be),
      .ack_tgl(ack_tgl), .ret_data(ret_data),
      .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_be(reg_be),
      .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data)
   );

endmodule

// File: tb/sim_axil_reg_bridge.sv
module sim_axil_reg_bridge;

   localparam int AW = 18;
   localparam int RW = AW - 2;

   logic          aclk = 1'b0, uclk = 1'b0;
   logic          aresetn = 1'b0, urst_n = 1'b0;
   logic [AW-1:0] awaddr = '0, araddr = '0;
   logic          awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
   logic [31:0]   wdata = '0;
   logic [3:0]    wstrb = '0;
   logic          bready = 1'b0, rready = 1'b0;
   logic          awready, wready, bvalid, arready, rvalid;
   logic [1:0]    bresp, rresp;
   logic [31:0]   rdata;
   logic          reg_wr_en, reg_rd_req;
   logic [RW-1:0] reg_addr;
   logic [31:0]   reg_wdata;
   logic [3:0]    reg_be;
   logic          reg_rd_valid = 1'b0;
   logic [31:0]   reg_rd_data = '0;

   always #5 aclk = ~aclk;   // 100 MHz
   always #7 uclk = ~uclk;   // unrelated user clock

   axil_reg_bridge u0 (
      .aclk(aclk), .aresetn(aresetn),
      .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
      .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
      .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .araddr(araddr), .arvalid(arvalid), .arready(arready),
      .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
      .uclk(uclk), .urst_n(urst_n),
      .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_be(reg_be),
      .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data)
   );

   int checks = 0, errors = 0;
   int n_wr = 0, n_rd = 0;
   logic [31:0] shadow [16];

   function automatic logic [31:0] merge(logic [31:0] old_v, logic [31:0] new_v, logic [3:0] be);
      logic [31:0] r = old_v;
      for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
      return r;
   endfunction

   function automatic int widx(logic [AW-1:0] a);
      return int'(a[5:2]);
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // register-file model on the user clock
   logic [31:0] mem [16];
   int wr_cnt = 0, rd_cnt = 0, seq = 0, last_wr_seq = 0, last_rd_seq = 0;
   int viol_both = 0, viol_addr = 0, lat_left = 0;
   bit pend = 0;
   logic [RW-1:0] pend_addr = '0, last_wr_addr = '0;

   initial for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end

   always @(posedge uclk) begin
      reg_rd_valid <= 1'b0;
      if (reg_wr_en && reg_rd_req) viol_both++;
      if (reg_wr_en) begin
         mem[reg_addr[3:0]] <= merge(mem[reg_addr[3:0]], reg_wdata, reg_be);
         wr_cnt++; seq++; last_wr_seq = seq;
         last_wr_addr = reg_addr;
      end
      if (reg_rd_req) begin
         pend = 1; pend_addr = reg_addr;
         lat_left = $urandom_range(0, 5);
         rd_cnt++; seq++; last_rd_seq = seq;
      end else if (pend) begin
         if (reg_addr != pend_addr) viol_addr++;
         if (lat_left == 0) begin
            reg_rd_valid <= 1'b1;
            reg_rd_data  <= mem[pend_addr[3:0]];
            pend = 0;
         end else lat_left--;
      end
   end

   task automatic axi_write(logic [AW-1:0] a, logic [31:0] d, logic [3:0] s);
      @(negedge aclk);
      awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
      #1;
      while (!(awready && wready)) begin @(negedge aclk); #1; end
      @(negedge aclk);
      awvalid = 0; wvalid = 0;
      while (!bvalid) @(negedge aclk);
      chk(bresp == 2'b00, "R7 bresp", {30'd0, bresp}, 32'd0);
      repeat ($urandom_range(0, 2)) begin
         @(negedge aclk);
         chk(bvalid, "R8 bvalid hold", {31'd0, bvalid}, 32'd1);
      end
      bready = 1;
      @(negedge aclk);
      bready = 0;
      shadow[widx(a)] = merge(shadow[widx(a)], d, s);
      n_wr++;
   endtask

   task automatic axi_read(logic [AW-1:0] a, output logic [31:0] d);
      logic [31:0] first;
      @(negedge aclk);
      araddr = a; arvalid = 1;
      #1;
      while (!arready) begin @(negedge aclk); #1; end
      @(negedge aclk);
      arvalid = 0;
      while (!rvalid) @(negedge aclk);
      first = rdata;
      chk(rresp == 2'b00, "R7 rresp", {30'd0, rresp}, 32'd0);
      repeat ($urandom_range(0, 2)) begin
         @(negedge aclk);
         chk(rvalid && rdata == first, "R8 rdata hold", rdata, first);
      end
      d = rdata;
      rready = 1;
      @(negedge aclk);
      rready = 0;
      n_rd++;
   endtask

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // watchdog
   int cyc = 0;
   always @(posedge aclk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         report();
      end
   end

   initial begin
      logic [31:0] got, rd_old;
      void'($urandom(32'd4242));
      repeat (4) @(negedge aclk);
      aresetn = 1; urst_n = 1;
      @(negedge aclk);
      // R9 reset state
      chk(!bvalid && !rvalid, "R9 resp idle", {30'd0, bvalid, rvalid}, 32'd0);
      chk(!reg_wr_en && !reg_rd_req, "R9 strobes idle", {30'd0, reg_wr_en, reg_rd_req}, 32'd0);
      chk(arready, "R9 arready", {31'd0, arready}, 32'd1);

      // R1: byte address 0x17 maps to word 5, low bits dropped
      axi_write(18'h17, 32'hDEAD_BEEF, 4'hF);
      chk(last_wr_addr == 16'd5, "R1 word address", {16'd0, last_wr_addr}, 32'd5);
      chk(wr_cnt == 1, "R10 one write strobe", wr_cnt, 1);
      // high address end
      axi_write(18'h3FFFC, 32'h0BAD_F00D, 4'hF);
      chk(last_wr_addr == 16'hFFFF, "R1 top word address", {16'd0, last_wr_addr}, 32'hFFFF);

      // R2 partial byte enables
      axi_write(18'h20, 32'hAABB_CCDD, 4'hF);
      axi_write(18'h20, 32'h1122_3344, 4'b0101);
      axi_read(18'h20, got);
      chk(got == 32'hAA22_CC44, "R2 byte merge", got, 32'hAA22_CC44);
      axi_write(18'h20, 32'h5566_7788, 4'b1000);
      axi_read(18'h22, got);
      chk(got == 32'h5522_CC44, "R2 top byte only", got, 32'h5522_CC44);

      // R3 read back first write
      axi_read(18'h14, got);
      chk(got == shadow[5], "R3 read data", got, shadow[5]);

      // R6 read and write collide
      rd_old = shadow[2];
      @(negedge aclk);
      araddr = 18'h08; arvalid = 1;
      awaddr = 18'h08; wdata = 32'hCAFE_0001; wstrb = 4'hF; awvalid = 1; wvalid = 1;
      rready = 1; bready = 1;
      #1;
      chk(arready && !awready && !wready, "R6 read first", {29'd0, arready, awready, wready}, 32'd4);
      @(negedge aclk);
      arvalid = 0;
      while (!rvalid) @(negedge aclk);
      got = rdata;
      #1;
      while (!(awready && wready)) begin @(negedge aclk); #1; end
      @(negedge aclk);
      awvalid = 0; wvalid = 0;
      while (!bvalid) @(negedge aclk);
      @(negedge aclk);
      rready = 0; bready = 0;
      n_rd++; n_wr++;
      shadow[2] = 32'hCAFE_0001;
      chk(got == rd_old, "R6 read saw old value", got, rd_old);
      chk(last_rd_seq < last_wr_seq, "R6 register order", last_rd_seq, last_wr_seq);
      axi_read(18'h08, got);
      chk(got == 32'hCAFE_0001, "R6 write applied after", got, 32'hCAFE_0001);

      // random mix
      for (int k = 0; k < 80; k++) begin
         logic [AW-1:0] a;
         a = AW'({$urandom_range(0, 15), 2'($urandom_range(0, 3))});
         if ($urandom_range(0, 1) == 1) begin
            axi_write(a, $urandom(), 4'($urandom_range(0, 15)));
         end else begin
            logic [31:0] exp;
            exp = shadow[widx(a)];
            axi_read(a, got);
            chk(got == exp, "R3 random read", got, exp);
         end
      end

      repeat (10) @(negedge aclk);
      chk(viol_both == 0, "R5 no strobe overlap", viol_both, 0);
      chk(viol_addr == 0, "R4 address held during read", viol_addr, 0);
      chk(wr_cnt == n_wr, "R10 write strobe count", wr_cnt, n_wr);
      chk(rd_cnt == n_rd, "R10 read strobe count", rd_cnt, n_rd);
      report();
   end

endmodule